// File: doc/BRIEF.md
# Staged Pipeline Control Register Chain

This block carries decoded control down a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). One main decoder turns the opcode held in the decode entry into a full control bundle. The bundle then travels with its instruction through the execute, memory and writeback entries. Each stage reads only its own group of fields. The datapath, register file, ALU and memories live elsewhere. Only the opcode decoder and the control registers are built here.

Two requests come from the surrounding hazard logic. A stall holds the fetch-to-decode entry still and sends an invalid no-op (a bubble) into execute. Older entries keep moving while the stall is held. A flush clears the valid bits of the decode entry and of the entry going into execute. Every control that changes state is gated by the valid bit of its own stage. An opcode the decoder does not know yields all-zero controls and raises an illegal-instruction flag.

Top module: `ctlpipe_top`

## Requirements
- R1: A word presented with `f_valid`=1 is in the decode entry after one rising edge. The decoder maps the 6-bit opcodes 0x00 (register ALU), 0x23 (load), 0x2B (store), 0x04 (branch-equal), 0x08 (add-immediate) and 0x0D (or-immediate) to the control values listed in R2 to R4.
- R2: The execute fields are visible one edge after decode. These are `ex_ext_op` (sign extend), `ex_alu_src` (immediate operand), `ex_alu_op` (0 add, 1 subtract, 2 function-field, 3 or) and `ex_dst_rd`. Register ALU gives 0,0,2,1. Load, store and add-immediate give 1,1,0,0. Branch gives 1,0,1,0. Or-immediate gives 0,1,3,0.
- R3: The memory fields are visible two edges after decode. `mem_wr` is 1 only for store. `mem_branch` is 1 only for branch.
- R4: The writeback fields are visible three edges after decode. `wb_reg_wr` is 1 for register ALU, load, add-immediate and or-immediate. `wb_mem_to_reg` is 1 only for load.
- R5: While `stall`=1, the decode entry keeps its instruction and valid bit. The entries in execute and memory still advance.
- R6: Each edge with `stall`=1 puts a bubble into execute: `ex_valid`=0 and all execute fields are 0.
- R7: An edge with `flush`=1 clears `dec_valid` and `ex_valid`, and the word fetched in that cycle is dropped. Flush takes priority over stall. The instruction that was in execute still moves to memory.
- R8: `mem_wr`, `mem_branch`, `wb_reg_wr` and `wb_mem_to_reg` are 1 only when their stage valid bit is 1. A word with `f_valid`=0 produces no state-changing control in any stage.
- R9: While `rst_n`=0, every valid bit and every state-changing control output is 0.
- R10: An unknown opcode in a valid decode entry raises `dec_illegal`. It travels on as a valid entry with all control fields 0. `dec_illegal` is 0 when `dec_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Hold decode entry, bubble into execute |
| flush | input | 1 | Clear decode and execute entries |
| f_valid | input | 1 | Fetched word is valid |
| f_op | input | 6 | Opcode of the fetched word |
| dec_valid | output | 1 | Decode entry valid |
| dec_illegal | output | 1 | Valid decode entry has an unknown opcode |
| ex_valid | output | 1 | Execute entry valid |
| ex_ext_op | output | 1 | Sign-extend the immediate |
| ex_alu_src | output | 1 | ALU second operand is the immediate |
| ex_alu_op | output | 3 | ALU operation code |
| ex_dst_rd | output | 1 | Destination taken from the third register field |
| mem_valid | output | 1 | Memory entry valid |
| mem_wr | output | 1 | Data memory write, gated by valid |
| mem_branch | output | 1 | Branch decision enable, gated by valid |
| wb_valid | output | 1 | Writeback entry valid |
| wb_reg_wr | output | 1 | Register file write, gated by valid |
| wb_mem_to_reg | output | 1 | Write data comes from memory, gated by valid |

## Verification
The assertions assume that `stall` and `flush` are plain level requests that are settled before each edge. They also assume that while a stall is held, the fetch side may change `f_op` freely, because the decode entry must ignore it. The stimulus drives all inputs one time unit after each edge. It raises stall and flush alone and together. It re-presents the fetched word after a stall releases, as a real fetch stage would.

// File: rtl/ctlpipe_pkg.sv
package ctlpipe_pkg;
   localparam int OPC_W   = 6;
   localparam int ALUOP_W = 3;

   localparam logic [OPC_W-1:0] OPC_ALU   = 6'h00;
   localparam logic [OPC_W-1:0] OPC_BREQ  = 6'h04;
   localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
   localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0D;
   localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
   localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;

   localparam logic [ALUOP_W-1:0] AOP_ADD  = 3'd0;
   localparam logic [ALUOP_W-1:0] AOP_SUB  = 3'd1;
   localparam logic [ALUOP_W-1:0] AOP_FUNC = 3'd2;
   localparam logic [ALUOP_W-1:0] AOP_OR   = 3'd3;

   typedef struct packed {
      logic               ext_op;
      logic               alu_src;
      logic [ALUOP_W-1:0] alu_op;
      logic               dst_rd;
   } ex_ctl_t;

   typedef struct packed {
      logic mem_wr;
      logic branch;
   } mem_ctl_t;

   typedef struct packed {
      logic reg_wr;
      logic mem_to_reg;
   } wb_ctl_t;

   typedef struct packed {
      ex_ctl_t  ex;
      mem_ctl_t mem;
      wb_ctl_t  wb;
   } ctl_bundle_t;

   typedef struct packed {
      mem_ctl_t mem;
      wb_ctl_t  wb;
   } late_ctl_t;
endpackage

// File: rtl/ctlpipe_decode.sv
module ctlpipe_decode
   import ctlpipe_pkg::*;
#(
   parameter int OP_W = 6
) (
   input  logic [OP_W-1:0] op,
   output ctl_bundle_t     ctl,
   output logic            unknown
);
   if (OP_W != OPC_W) begin : g_bad_opw
      $error("ctlpipe_decode: OP_W must equal the package opcode width");
   end

   always_comb begin
      ctl     = '0;
      unknown = 1'b0;
      case (op)
         OPC_ALU: begin
            ctl.ex.alu_op  = AOP_FUNC;
            ctl.ex.dst_rd  = 1'b1;
            ctl.wb.reg_wr  = 1'b1;
         end
         OPC_LOAD: begin
            ctl.ex.ext_op     = 1'b1;
            ctl.ex.alu_src    = 1'b1;
            ctl.ex.alu_op     = AOP_ADD;
            ctl.wb.reg_wr     = 1'b1;
            ctl.wb.mem_to_reg = 1'b1;
         end
         OPC_STORE: begin
            ctl.ex.ext_op  = 1'b1;
            ctl.ex.alu_src = 1'b1;
            ctl.ex.alu_op  = AOP_ADD;
            ctl.mem.mem_wr = 1'b1;
         end
         OPC_BREQ: begin
            ctl.ex.ext_op  = 1'b1;
            ctl.ex.alu_op  = AOP_SUB;
            ctl.mem.branch = 1'b1;
         end
         OPC_ADDI: begin
            ctl.ex.ext_op  = 1'b1;
            ctl.ex.alu_src = 1'b1;
            ctl.ex.alu_op  = AOP_ADD;
            ctl.wb.reg_wr  = 1'b1;
         end
         OPC_ORI: begin
            ctl.ex.alu_src = 1'b1;
            ctl.ex.alu_op  = AOP_OR;
            ctl.wb.reg_wr  = 1'b1;
         end
         default: unknown = 1'b1;
      endcase
   end
endmodule

// File: rtl/ctlpipe_stage.sv
module ctlpipe_stage #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold,
   input  logic         kill,
   input  logic [W-1:0] d,
   input  logic         d_valid,
   output logic [W-1:0] q,
   output logic         q_valid
);
   if (W < 1) begin : g_bad_w
      $error("ctlpipe_stage: W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q       <= '0;
         q_valid <= 1'b0;
      end else if (kill) begin
         q       <= '0;
         q_valid <= 1'b0;
      end else if (!hold) begin
         q       <= d;
         q_valid <= d_valid;
      end
   end

   a_r7_kill_clears: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> !q_valid && (q == '0));
   a_r5_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      hold && !kill |=> $stable(q) && $stable(q_valid));
endmodule

// File: rtl/ctlpipe_top.sv
module ctlpipe_top
   import ctlpipe_pkg::*;
#(
   parameter int OP_W              = 6,
   parameter bit ILLEGAL_AS_BUBBLE = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            stall,
   input  logic            flush,
   input  logic            f_valid,
   input  logic [OP_W-1:0] f_op,
   output logic            dec_valid,
   output logic            dec_illegal,
   output logic            ex_valid,
   output logic            ex_ext_op,
   output logic            ex_alu_src,
   output logic [2:0]      ex_alu_op,
   output logic            ex_dst_rd,
   output logic            mem_valid,
   output logic            mem_wr,
   output logic            mem_branch,
   output logic            wb_valid,
   output logic            wb_reg_wr,
   output logic            wb_mem_to_reg
);
   localparam int BUN_W  = $bits(ctl_bundle_t);
   localparam int LATE_W = $bits(late_ctl_t);
   localparam int WB_W   = $bits(wb_ctl_t);

   if (ALUOP_W != 3) begin : g_bad_aop
      $error("ctlpipe_top: ALU op port is 3 bits wide");
   end

   logic [OP_W-1:0] dec_op;
   ctl_bundle_t     dec_ctl;
   logic            dec_unknown;
   ctl_bundle_t     ex_q;
   late_ctl_t       mem_q;
   wb_ctl_t         wb_q;
   logic            ill_kill;
   logic            idex_kill;

   ctlpipe_stage #(.W(OP_W)) u_ifid (
      .clk(clk), .rst_n(rst_n), .hold(stall), .kill(flush),
      .d(f_op), .d_valid(f_valid), .q(dec_op), .q_valid(dec_valid));

   ctlpipe_decode #(.OP_W(OP_W)) u_dec (
      .op(dec_op), .ctl(dec_ctl), .unknown(dec_unknown));

   assign dec_illegal = dec_valid & dec_unknown;

   if (ILLEGAL_AS_BUBBLE) begin : g_ill_bubble
      assign ill_kill = dec_illegal;
   end else begin : g_ill_pass
      assign ill_kill = 1'b0;
   end

   assign idex_kill = stall | flush | ill_kill;

   ctlpipe_stage #(.W(BUN_W)) u_idex (
      .clk(clk), .rst_n(rst_n), .hold(1'b0), .kill(idex_kill),
      .d(dec_ctl), .d_valid(dec_valid), .q(ex_q), .q_valid(ex_valid));

   ctlpipe_stage #(.W(LATE_W)) u_exmem (
      .clk(clk), .rst_n(rst_n), .hold(1'b0), .kill(1'b0),
      .d({ex_q.mem, ex_q.wb}), .d_valid(ex_valid), .q(mem_q), .q_valid(mem_valid));

   ctlpipe_stage #(.W(WB_W)) u_memwb (
      .clk(clk), .rst_n(rst_n), .hold(1'b0), .kill(1'b0),
      .d(mem_q.wb), .d_valid(mem_valid), .q(wb_q), .q_valid(wb_valid));

   assign ex_ext_op     = ex_q.ex.ext_op;
   assign ex_alu_src    = ex_q.ex.alu_src;
   assign ex_alu_op     = ex_q.ex.alu_op;
   assign ex_dst_rd     = ex_q.ex.dst_rd;
   assign mem_wr        = mem_q.mem.mem_wr & mem_valid;
   assign mem_branch    = mem_q.mem.branch & mem_valid;
   assign wb_reg_wr     = wb_q.reg_wr & wb_valid;
   assign wb_mem_to_reg = wb_q.mem_to_reg & wb_valid;

   a_r6_stall_bubble: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !ex_valid && ex_alu_op == 3'd0 && !ex_alu_src);
   a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !dec_valid && !ex_valid);
   a_r3_mem_advances: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> mem_valid == $past(ex_valid));
   a_r4_wb_advances: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> wb_valid == $past(mem_valid));
   a_r8_wb_from_valid: assert property (@(posedge clk) disable iff (!rst_n)
      wb_reg_wr |-> $past(mem_valid));
   a_r10_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
      dec_illegal && !stall && !flush |=> !ex_ext_op && !ex_alu_src && ex_alu_op == 3'd0);
endmodule

// File: tb/sim_ctlpipe_top.sv
`timescale 1ns/100ps
module sim_ctlpipe_top;
   logic       clk = 1'b0;
   logic       rst_n, stall, flush, f_valid;
   logic [5:0] f_op;
   logic       dec_valid, dec_illegal, ex_valid, ex_ext_op, ex_alu_src, ex_dst_rd;
   logic [2:0] ex_alu_op;
   logic       mem_valid, mem_wr, mem_branch, wb_valid, wb_reg_wr, wb_mem_to_reg;
   int         n_chk = 0;
   int         n_bad = 0;

   always #2.5 clk = ~clk;

   ctlpipe_top u0 (
      .clk(clk), .rst_n(rst_n), .stall(stall), .flush(flush), .f_valid(f_valid), .f_op(f_op),
      .dec_valid(dec_valid), .dec_illegal(dec_illegal), .ex_valid(ex_valid),
      .ex_ext_op(ex_ext_op), .ex_alu_src(ex_alu_src), .ex_alu_op(ex_alu_op),
      .ex_dst_rd(ex_dst_rd), .mem_valid(mem_valid), .mem_wr(mem_wr),
      .mem_branch(mem_branch), .wb_valid(wb_valid), .wb_reg_wr(wb_reg_wr),
      .wb_mem_to_reg(wb_mem_to_reg));

   // {op[16:11], illegal[10], ext[9], src[8], aluop[7:5], dst[4], mw[3], br[2], rw[1], m2r[0]}
   localparam logic [16:0] VEC [0:6] = '{
      {6'h00, 1'b0, 1'b0, 1'b0, 3'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
      {6'h23, 1'b0, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
      {6'h2B, 1'b0, 1'b1, 1'b1, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
      {6'h04, 1'b0, 1'b1, 1'b0, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
      {6'h08, 1'b0, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
      {6'h0D, 1'b0, 1'b0, 1'b1, 3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
      {6'h3F, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
   };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic fetch(input logic v, input logic [5:0] op, input logic st, input logic fl);
      f_valid = v; f_op = op; stall = st; flush = fl;
   endtask

   initial begin
      rst_n = 1'b0;
      fetch(1'b1, 6'h2B, 1'b0, 1'b0);
      repeat (3) tick();
      chk("R9 valid bits in reset", {4'd0, dec_valid, ex_valid, mem_valid, wb_valid}, 8'd0);
      chk("R9 writes in reset", {5'd0, mem_wr, mem_branch, wb_reg_wr}, 8'd0);
      rst_n = 1'b1;
      fetch(1'b0, 6'h00, 1'b0, 1'b0);
      repeat (4) tick();

      // table walk: R1..R4, R10
      for (int i = 0; i < 7; i++) begin
         logic [16:0] v;
         v = VEC[i];
         fetch(1'b1, v[16:11], 1'b0, 1'b0);
         tick();
         fetch(1'b0, 6'h00, 1'b0, 1'b0);
         chk("R1 dec_valid", {7'd0, dec_valid}, 8'd1);
         chk("R10 dec_illegal", {7'd0, dec_illegal}, {7'd0, v[10]});
         tick();
         chk("R2 ex_valid", {7'd0, ex_valid}, 8'd1);
         chk("R2 ex fields", {2'd0, ex_ext_op, ex_alu_src, ex_alu_op, ex_dst_rd}, {2'd0, v[9:4]});
         tick();
         chk("R3 mem fields", {5'd0, mem_valid, mem_wr, mem_branch}, {5'd0, 1'b1, v[3:2]});
         tick();
         chk("R4 wb fields", {5'd0, wb_valid, wb_reg_wr, wb_mem_to_reg}, {5'd0, 1'b1, v[1:0]});
      end

      // R8: invalid fetch of store / unknown opcode
      fetch(1'b0, 6'h3F, 1'b0, 1'b0);
      tick();
      chk("R10 illegal masked when invalid", {6'd0, dec_valid, dec_illegal}, 8'd0);
      fetch(1'b0, 6'h2B, 1'b0, 1'b0);
      tick(); tick(); tick();
      chk("R8 invalid store no write", {6'd0, mem_valid, mem_wr}, 8'd0);

      // R5/R6: stall with store in execute
      fetch(1'b1, 6'h2B, 1'b0, 1'b0); tick();
      fetch(1'b1, 6'h08, 1'b0, 1'b0); tick();
      fetch(1'b1, 6'h23, 1'b1, 1'b0); tick();
      chk("R5 older store advances", {6'd0, mem_valid, mem_wr}, 8'd3);
      chk("R6 bubble in ex", {7'd0, ex_valid}, 8'd0);
      chk("R6 bubble fields zero", {2'd0, ex_ext_op, ex_alu_src, ex_alu_op, ex_dst_rd}, 8'd0);
      chk("R5 decode held", {7'd0, dec_valid}, 8'd1);
      fetch(1'b1, 6'h23, 1'b0, 1'b0); tick();
      chk("R5 held addi reaches ex", {1'd0, ex_valid, ex_ext_op, ex_alu_src, ex_alu_op, ex_dst_rd}, 8'b0111_0000);
      chk("R6 bubble reaches mem", {7'd0, mem_valid}, 8'd0);
      fetch(1'b0, 6'h00, 1'b0, 1'b0); tick();
      chk("R5 load after stall in ex", {7'd0, ex_valid}, 8'd1);
      tick();
      chk("R4 addi writeback", {6'd0, wb_valid, wb_reg_wr}, 8'd3);
      tick();
      chk("R4 load mem_to_reg", {6'd0, wb_reg_wr, wb_mem_to_reg}, 8'd3);

      // R7: flush
      fetch(1'b1, 6'h08, 1'b0, 1'b0); tick();
      fetch(1'b1, 6'h04, 1'b0, 1'b0); tick();
      fetch(1'b1, 6'h2B, 1'b0, 1'b1); tick();
      chk("R7 flush clears dec/ex", {6'd0, dec_valid, ex_valid}, 8'd0);
      chk("R7 ex entry advances", {7'd0, mem_valid}, 8'd1);
      fetch(1'b0, 6'h00, 1'b0, 1'b0); tick();
      chk("R7 killed branch no effect", {6'd0, mem_valid, mem_branch}, 8'd0);
      chk("R7 older addi writes", {6'd0, wb_valid, wb_reg_wr}, 8'd3);
      tick();
      chk("R7 dropped store no write", {6'd0, mem_valid, mem_wr}, 8'd0);

      // R7: flush wins over stall
      fetch(1'b1, 6'h00, 1'b0, 1'b0); tick();
      fetch(1'b1, 6'h00, 1'b1, 1'b1); tick();
      chk("R7 flush over stall", {6'd0, dec_valid, ex_valid}, 8'd0);
      fetch(1'b0, 6'h00, 1'b0, 1'b0);
      tick(); tick(); tick();
      chk("R8 nothing written after flush", {6'd0, wb_valid, wb_reg_wr}, 8'd0);

      // R9: reset mid-run
      fetch(1'b1, 6'h00, 1'b0, 1'b0); tick(); tick();
      rst_n = 1'b0; tick();
      chk("R9 mid-run reset", {4'd0, dec_valid, ex_valid, mem_valid, wb_valid}, 8'd0);
      rst_n = 1'b1;

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule